// File: doc/BRIEF.md
# Masked Address Breakpoint Comparator

This block sits beside a CPU bus and watches every access. It holds two independent comparator channels. Each channel owns a programmed address (high byte and low byte) and an expansion page byte. When a valid bus access matches a channel's compare pattern, that channel raises a trigger pulse one clock later. The pattern is chosen by a shared control byte. For each channel, this byte gives a two-bit byte mask and a pair of bits that make the read/write direction part of the match.

The width of the compare follows the bus. While a program page is selected, a full compare spans 20 bits: six page bits, the lower six bits of the high address byte, and the whole low byte. With no page selected it spans the full 16-bit address and the page register plays no part. Masking the low byte turns the channel into a 256-byte window match. Masking both bytes turns it into a match on any access to the programmed page. The mask code that would mask only the high byte makes no sense, so the logic treats it as a full compare.

Software programs the channels through a byte-wide register port. The port has a write strobe and an offset, and every register can be read back at any time through a combinational read path.

Top module: `addr_bkpt_cmp`

## Requirements
- R1: After reset, every register reads 0x00 and both trigger outputs are low.
- R2: Register offsets are: 0 = control, 1/2/3 = channel 0 page/high/low, 4/5/6 = channel 1 page/high/low. A write with `reg_we` high stores `reg_wdata` at the clock edge. `reg_rdata` always shows the register at `reg_ofs` (0x00 for unused offsets). Control bits: [7:6] = channel 0 mask {hi-mask, lo-mask}; [5:4] = channel 1 mask; [3]/[2] = channel 0 R/W enable/value; [1]/[0] = channel 1 R/W enable/value.
- R3: With lo-mask = 0 and `bus_pg_sel` = 1, a channel matches when `bus_page` equals page[5:0], `bus_addr[13:8]` equals high[5:0] and `bus_addr[7:0]` equals low. `bus_addr[15:14]` is ignored.
- R4: With lo-mask = 0 and `bus_pg_sel` = 0, a channel matches when `bus_addr` equals {high, low}. The page register and `bus_page` are ignored.
- R5: The mask code hi-mask = 1, lo-mask = 0 behaves exactly like a full compare (R3/R4).
- R6: With hi-mask = 0 and lo-mask = 1, the low address byte is not compared. The high byte (and the page when selected) is compared as in R3/R4.
- R7: With both mask bits set, a channel matches any access whose `bus_page` equals page[5:0] while `bus_pg_sel` = 1. It never matches while `bus_pg_sel` = 0.
- R8: With the channel's R/W enable at 0, `bus_rw` is ignored. With it at 1, a match also needs `bus_rw` to equal the channel's programmed R/W value (1 = read).
- R9: `trig[c]` is high in the cycle after a matching access that had `bus_vld` high, for exactly one clock per such access. It stays low when `bus_vld` is low. The two channels trigger independently, including in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_ofs | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data at `reg_ofs` |
| bus_vld | input | 1 | Bus access valid strobe |
| bus_addr | input | 16 | Bus address |
| bus_page | input | 6 | Bus expansion page |
| bus_pg_sel | input | 1 | A program page is selected |
| bus_rw | input | 1 | Access direction, 1 = read |
| trig | output | 2 | Per-channel registered trigger pulse |

## Verification
On every cycle, assertions check that a trigger only follows a valid access. They also check that an enabled R/W compare agreed with the bus, that a page-only trigger came from the selected page, and that a 16-bit full trigger matched the whole address. A separate assertion checks that a control write lands in the register. Other behaviours can only be shown by the bench's scenarios with a reference model: ignored address bits in the 20-bit compare, the forced full compare for the nonsense mask code, low-byte masking, missed accesses, back-to-back pulses and simultaneous channel hits.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int NCH    = 2;
  localparam int ADDR_W = 16;
  localparam int PAGE_W = 6;
  localparam int DW     = 8;
  localparam int OFS_W  = 4;
  localparam int HI_CMP = ADDR_W - 8 - 2; // high bits compared when a page is selected

  typedef enum logic [1:0] {
    CMP_FULL = 2'd0,
    CMP_HIGH = 2'd1,
    CMP_PAGE = 2'd2
  } cmp_mode_t;

  typedef struct packed {
    logic          mbh;
    logic          mbl;
    logic          rwe;
    logic          rwv;
    logic [DW-1:0] page;
    logic [DW-1:0] hi;
    logic [DW-1:0] lo;
  } chan_cfg_t;

  // Control byte fields for channel c: mask pair at [7-2c:6-2c], rw pair at [3-2c:2-2c]
  function automatic logic [3:0] ctl_slice(input logic [DW-1:0] ctl, input int c);
    return {ctl[7-2*c], ctl[6-2*c], ctl[3-2*c], ctl[2-2*c]};
  endfunction

  function automatic cmp_mode_t decode_mode(input logic mbh, input logic mbl);
    if (!mbl)     return CMP_FULL;  // covers the forced-full case mbh=1, mbl=0
    else if (!mbh) return CMP_HIGH;
    else          return CMP_PAGE;
  endfunction

  function automatic logic addr_match(input cmp_mode_t md, input chan_cfg_t cf,
                                      input logic ps, input logic [ADDR_W-1:0] a,
                                      input logic [PAGE_W-1:0] pg);
    logic pg_ok, hi_ok, lo_ok;
    pg_ok = (pg == cf.page[PAGE_W-1:0]);
    hi_ok = ps ? (a[HI_CMP+7:8] == cf.hi[HI_CMP-1:0]) : (a[ADDR_W-1:8] == cf.hi);
    lo_ok = (a[7:0] == cf.lo);
    case (md)
      CMP_FULL: return (ps ? pg_ok : 1'b1) && hi_ok && lo_ok;
      CMP_HIGH: return (ps ? pg_ok : 1'b1) && hi_ok;
      CMP_PAGE: return ps && pg_ok;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int N_CH = NCH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [OFS_W-1:0]     ofs,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  output logic [DW-1:0]        ctrl,
  output logic [N_CH-1:0][DW-1:0] page,
  output logic [N_CH-1:0][DW-1:0] hi,
  output logic [N_CH-1:0][DW-1:0] lo
);
  localparam int CTRL_OFS = 0;
  localparam int CH_SPAN  = 3;

  logic ctrl_wr;
  assign ctrl_wr = we && (ofs == OFS_W'(CTRL_OFS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else if (ctrl_wr) ctrl <= wdata;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam int BASE = 1 + CH_SPAN * c;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        page[c] <= '0;
        hi[c]   <= '0;
        lo[c]   <= '0;
      end else if (we) begin
        if (ofs == OFS_W'(BASE))     page[c] <= wdata;
        if (ofs == OFS_W'(BASE + 1)) hi[c]   <= wdata;
        if (ofs == OFS_W'(BASE + 2)) lo[c]   <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (ofs == OFS_W'(CTRL_OFS)) rdata = ctrl;
    for (int c = 0; c < N_CH; c++) begin
      if (ofs == OFS_W'(1 + CH_SPAN * c)) rdata = page[c];
      if (ofs == OFS_W'(2 + CH_SPAN * c)) rdata = hi[c];
      if (ofs == OFS_W'(3 + CH_SPAN * c)) rdata = lo[c];
    end
  end

  // R2
  ctrl_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_wr) |-> (ctrl == $past(wdata)));
endmodule

// File: rtl/bkpt_chan.sv
module bkpt_chan
  import bkpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  chan_cfg_t         cfg,
  input  logic              bus_vld,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PAGE_W-1:0] bus_page,
  input  logic              bus_pg_sel,
  input  logic              bus_rw,
  output logic              trig
);
  cmp_mode_t mode;
  logic      addr_ok;
  logic      rw_ok;
  logic      hit;

  assign mode    = decode_mode(cfg.mbh, cfg.mbl);
  assign addr_ok = addr_match(mode, cfg, bus_pg_sel, bus_addr, bus_page);
  assign rw_ok   = !cfg.rwe || (bus_rw == cfg.rwv);
  assign hit     = bus_vld && addr_ok && rw_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig <= 1'b0;
    else        trig <= hit;
  end

  // R9
  trig_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(bus_vld));

  // R8
  rw_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && $past(cfg.rwe)) |-> ($past(bus_rw) == $past(cfg.rwv)));

  // R7
  page_only_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && $past(cfg.mbh) && $past(cfg.mbl)) |->
      ($past(bus_pg_sel) && ($past(bus_page) == $past(cfg.page[PAGE_W-1:0]))));

  // R4
  full16_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !$past(cfg.mbl) && !$past(bus_pg_sel)) |->
      ($past(bus_addr) == {$past(cfg.hi), $past(cfg.lo)}));
endmodule

// File: rtl/addr_bkpt_cmp.sv
module addr_bkpt_cmp
  import bkpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [OFS_W-1:0]  reg_ofs,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              bus_vld,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PAGE_W-1:0] bus_page,
  input  logic              bus_pg_sel,
  input  logic              bus_rw,
  output logic [NCH-1:0]    trig
);
  logic [DW-1:0]           ctrl;
  logic [NCH-1:0][DW-1:0]  page_r, hi_r, lo_r;

  bkpt_regs #(.N_CH(NCH)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .ofs   (reg_ofs),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .ctrl  (ctrl),
    .page  (page_r),
    .hi    (hi_r),
    .lo    (lo_r)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_cmp
    chan_cfg_t  cfg;
    logic [3:0] fld;
    assign fld = ctl_slice(ctrl, c);
    assign cfg = '{mbh: fld[3], mbl: fld[2], rwe: fld[1], rwv: fld[0],
                   page: page_r[c], hi: hi_r[c], lo: lo_r[c]};

    bkpt_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg        (cfg),
      .bus_vld    (bus_vld),
      .bus_addr   (bus_addr),
      .bus_page   (bus_page),
      .bus_pg_sel (bus_pg_sel),
      .bus_rw     (bus_rw),
      .trig       (trig[c])
    );
  end
endmodule

// File: tb/sim_addr_bkpt_cmp.sv
module sim_addr_bkpt_cmp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_ofs = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        bus_vld = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [5:0]  bus_page = '0;
  logic        bus_pg_sel = 1'b0;
  logic        bus_rw = 1'b0;
  logic [1:0]  trig;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [1:0] q_exp[$];
  string      q_tag[$];

  logic [7:0] sh_ctrl;
  logic [7:0] sh_page[2];
  logic [7:0] sh_hi[2];
  logic [7:0] sh_lo[2];

  always #2 clk = ~clk;

  addr_bkpt_cmp u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_ofs(reg_ofs),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_vld(bus_vld),
    .bus_addr(bus_addr), .bus_page(bus_page), .bus_pg_sel(bus_pg_sel),
    .bus_rw(bus_rw), .trig(trig)
  );

  // Reference: masked 22-bit compare of {page, addr}
  function automatic bit ref_hit(int c, bit ps, logic [15:0] a, logic [5:0] pg, bit rw, bit v);
    bit mh, ml, re, rv;
    logic [21:0] want, got, msk;
    mh = sh_ctrl[7-2*c]; ml = sh_ctrl[6-2*c];
    re = sh_ctrl[3-2*c]; rv = sh_ctrl[2-2*c];
    if (!v) return 1'b0;
    if (re && (rw != rv)) return 1'b0;
    want = {sh_page[c][5:0], sh_hi[c], sh_lo[c]};
    got  = {pg, a};
    msk  = '1;
    if (ps) msk[15:14] = 2'b00; else msk[21:16] = 6'd0;
    if (ml) msk[7:0] = 8'd0;
    if (ml && mh) begin
      if (!ps) return 1'b0;
      msk[15:8] = 8'd0;
    end
    return ((want ^ got) & msk) == 22'd0;
  endfunction

  task automatic acc(bit ps, logic [15:0] a, logic [5:0] pg, bit rw, bit v, string tag);
    logic [1:0] e;
    @(negedge clk);
    reg_we = 1'b0;
    bus_pg_sel = ps; bus_addr = a; bus_page = pg; bus_rw = rw; bus_vld = v;
    e = {ref_hit(1, ps, a, pg, rw, v), ref_hit(0, ps, a, pg, rw, v)};
    @(posedge clk); #1;
    q_exp.push_back(e); q_tag.push_back(tag);
  endtask

  task automatic wr(logic [3:0] o, logic [7:0] d);
    @(negedge clk);
    bus_vld = 1'b0; reg_we = 1'b1; reg_ofs = o; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
    if (o == 0) sh_ctrl = d;
    else if (o >= 1 && o <= 6) begin
      case ((o - 1) % 3)
        0: sh_page[(o-1)/3] = d;
        1: sh_hi[(o-1)/3]   = d;
        default: sh_lo[(o-1)/3] = d;
      endcase
    end
    q_exp.push_back(2'b00); q_tag.push_back("R2");
  endtask

  task automatic rd_chk(logic [3:0] o, logic [7:0] e, string tag);
    @(negedge clk);
    reg_ofs = o;
    #1;
    n_chk++;
    if (reg_rdata !== e) begin
      n_fail++;
      $display("FAIL %s: rdata at ofs %0d = %h expected %h", tag, o, reg_rdata, e);
    end
  endtask

  // Monitor: compares queued expectations against the trigger output
  initial begin
    forever begin
      @(negedge clk);
      while (q_exp.size() > 0) begin
        logic [1:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        n_chk++;
        if (trig !== e) begin
          n_fail++;
          $display("FAIL %s: trig = %b expected %b", t, trig, e);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    sh_ctrl = '0;
    for (int i = 0; i < 2; i++) begin sh_page[i] = '0; sh_hi[i] = '0; sh_lo[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    n_chk++;
    if (trig !== 2'b00) begin n_fail++; $display("FAIL R1: trig = %b expected 00", trig); end
    for (int o = 0; o < 7; o++) rd_chk(4'(o), 8'h00, "R1");
    @(negedge clk); rst_n = 1'b1;

    // R2: programming and readback
    wr(0, 8'h00);
    wr(1, 8'h15); wr(2, 8'hF4); wr(3, 8'h56);
    wr(4, 8'h2A); wr(5, 8'h12); wr(6, 8'h9C);
    rd_chk(1, 8'h15, "R2"); rd_chk(2, 8'hF4, "R2"); rd_chk(3, 8'h56, "R2");
    rd_chk(4, 8'h2A, "R2"); rd_chk(5, 8'h12, "R2"); rd_chk(6, 8'h9C, "R2");
    rd_chk(9, 8'h00, "R2");

    // R3: 20-bit compare with page selected
    acc(1, 16'h3456, 6'h15, 0, 1, "R3");
    acc(1, 16'hF456, 6'h15, 0, 1, "R3");
    acc(1, 16'h3456, 6'h16, 0, 1, "R3");
    acc(1, 16'h3457, 6'h15, 0, 1, "R3");

    // R4: 16-bit compare, page ignored
    acc(0, 16'hF456, 6'h00, 0, 1, "R4");
    acc(0, 16'h3456, 6'h15, 0, 1, "R4");
    acc(0, 16'h129C, 6'h3F, 1, 1, "R4");

    // R5: nonsense mask code forces full compare
    wr(0, 8'h80); rd_chk(0, 8'h80, "R2");
    acc(0, 16'hF457, 6'h00, 0, 1, "R5");
    acc(0, 16'hF400, 6'h00, 0, 1, "R5");
    acc(0, 16'hF456, 6'h00, 0, 1, "R5");

    // R6: low byte masked
    wr(0, 8'h40);
    acc(0, 16'hF4AA, 6'h00, 0, 1, "R6");
    acc(0, 16'hF5AA, 6'h00, 0, 1, "R6");
    acc(1, 16'h34AA, 6'h15, 0, 1, "R6");
    acc(1, 16'h34AA, 6'h14, 0, 1, "R6");

    // R7: page-only match
    wr(0, 8'hF0);
    acc(1, 16'h0000, 6'h15, 0, 1, "R7");
    acc(1, 16'hBEEF, 6'h2A, 1, 1, "R7");
    acc(0, 16'hF456, 6'h15, 0, 1, "R7");
    acc(0, 16'h129C, 6'h2A, 0, 1, "R7");

    // R8: read/write compare
    wr(0, 8'h0C);
    acc(0, 16'hF456, 6'h00, 1, 1, "R8");
    acc(0, 16'hF456, 6'h00, 0, 1, "R8");
    wr(0, 8'h02);
    acc(0, 16'h129C, 6'h00, 0, 1, "R8");
    acc(0, 16'h129C, 6'h00, 1, 1, "R8");
    acc(0, 16'hF456, 6'h00, 1, 1, "R8");
    acc(0, 16'hF456, 6'h00, 0, 1, "R8");

    // R9: valid gating, back-to-back pulses, simultaneous channels
    wr(0, 8'h00);
    acc(0, 16'hF456, 6'h00, 0, 0, "R9");
    acc(0, 16'hF456, 6'h00, 0, 1, "R9");
    acc(0, 16'hF456, 6'h00, 0, 1, "R9");
    acc(0, 16'hF456, 6'h00, 0, 1, "R9");
    acc(0, 16'hF456, 6'h00, 0, 0, "R9");
    wr(5, 8'hF4); wr(6, 8'h56);
    acc(0, 16'hF456, 6'h00, 0, 1, "R9");
    acc(0, 16'h0000, 6'h00, 0, 1, "R9");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule